// File: doc/BRIEF.md
# UART Interrupt Source and Identification Logic

This block collects the four interrupt conditions of a serial port (a receive line error, a received character ready to read, an empty transmit holding register and a change on the modem control inputs). It masks each condition with its own enable bit and drives one interrupt request. The request is a level, not a pulse. It stays high for as long as any enabled condition is still pending. A service routine therefore has to poll and clear every source before it returns, because clearing only one of them does not make the line fall and rise again.

An identification value names the most urgent enabled source that is pending, or reports that none is pending. Each condition is cleared by the access that services it. The transmit-empty condition is also cleared when the identification value is read while it names that condition. All source events and register accesses arrive as single-cycle strobes. Outputs come from registered state only.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the request output is 0, the identification value is 3'b001 and all enable bits and pending conditions are clear.
- R2: The request output is high in every cycle in which at least one enabled condition is pending. Clearing one of two enabled pending conditions leaves it high.
- R3: A condition whose enable bit is 0 affects neither the request output nor the identification value, but it stays pending. Setting its enable bit later raises the request. Enable bits are written with `en_wr`: bit 0 line error, bit 1 receive data, bit 2 transmit empty, bit 3 modem change.
- R4: The identification value reports the pending enabled condition with the highest priority. From highest to lowest: line error (3'b110), receive data (3'b100), transmit empty (3'b010), modem change (3'b000).
- R5: With no enabled condition pending, the identification value is 3'b001 (bit 0 set means nothing pending).
- R6: A read of the identification value (`rd_ident`) in a cycle in which it reports 3'b010 clears the transmit-empty condition.
- R7: `rd_line` clears the line error condition, `rd_data` clears receive data, `rd_modem` clears modem change, and `wr_hold` clears transmit empty.
- R8: A condition whose event strobe arrives in the same cycle as an access that would clear it stays pending.
- R9: A read of the identification value that reports any value other than 3'b010 clears no condition.
- R10: A source event, an access or an enable write changes the outputs from the cycle that follows the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_line_err | input | 1 | Strobe: receive line error detected |
| ev_rx_avail | input | 1 | Strobe: received character available |
| ev_tx_empty | input | 1 | Strobe: transmit holding register became empty |
| ev_modem_chg | input | 1 | Strobe: modem input changed |
| en_wr | input | 1 | Strobe: load the enable register |
| en_wdata | input | 4 | New enable bits |
| rd_ident | input | 1 | Strobe: identification value is read |
| rd_line | input | 1 | Strobe: line status register is read |
| rd_data | input | 1 | Strobe: receive data register is read |
| rd_modem | input | 1 | Strobe: modem status register is read |
| wr_hold | input | 1 | Strobe: transmit holding register is written |
| irq_o | output | 1 | Level interrupt request |
| ident_o | output | 3 | Identification value |

## Verification
The assertions check on every cycle that the request level agrees with the "nothing pending" bit of the identification value and that a masked-out state never raises the request. They also check that the top-priority line error always wins the identification, that each clearing access removes its condition unless a new event arrives in the same cycle, and that an identification read which names another source leaves transmit-empty in place. Only the bench scenarios can show the complete priority walk-down while a routine services several sources in turn, and that a masked condition survives until it is enabled again. They also cover that an identification read made while everything is masked leaves the hidden transmit-empty condition pending.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int NSRC    = 4;
    localparam int ID_W    = 3;
    localparam int IDX_LSR = 0;   // highest priority
    localparam int IDX_RXD = 1;
    localparam int IDX_TXE = 2;
    localparam int IDX_MSC = 3;   // lowest priority

    localparam logic [ID_W-1:0] ID_NONE = 3'b001;

    function automatic logic [1:0] src_code(input int idx);
        case (idx)
            IDX_LSR: src_code = 2'b11;
            IDX_RXD: src_code = 2'b10;
            IDX_TXE: src_code = 2'b01;
            default: src_code = 2'b00;
        endcase
    endfunction
endpackage

// File: rtl/uirq_flags.sv
module uirq_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] pend;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            // a new event beats a clearing access in the same cycle
            if (set_i[i])
                st_d.pend[i] = 1'b1;
            else if (clr_i[i])
                st_d.pend[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/uirq_enable.sv
module uirq_enable #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] en_o
);
    typedef struct packed {
        logic [N-1:0] en;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i)
            st_d.en = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign en_o = st_q.en;
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]    active_i,
    output logic [N-1:0]    pick_o,
    output logic [ID_W-1:0] ident_o
);
    // pick_o: one-hot winner, lowest index = highest priority
    always_comb begin
        pick_o  = '0;
        ident_o = ID_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (active_i[i]) begin
                pick_o    = '0;
                pick_o[i] = 1'b1;
                ident_o   = {src_code(i), 1'b0};
            end
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_line_err,
    input  logic            ev_rx_avail,
    input  logic            ev_tx_empty,
    input  logic            ev_modem_chg,
    input  logic            en_wr,
    input  logic [NSRC-1:0] en_wdata,
    input  logic            rd_ident,
    input  logic            rd_line,
    input  logic            rd_data,
    input  logic            rd_modem,
    input  logic            wr_hold,
    output logic            irq_o,
    output logic [ID_W-1:0] ident_o
);
    logic [NSRC-1:0] set_v, clr_v, pend_q, en_q, active, pick;

    always_comb begin
        set_v          = '0;
        set_v[IDX_LSR] = ev_line_err;
        set_v[IDX_RXD] = ev_rx_avail;
        set_v[IDX_TXE] = ev_tx_empty;
        set_v[IDX_MSC] = ev_modem_chg;

        clr_v          = '0;
        clr_v[IDX_LSR] = rd_line;
        clr_v[IDX_RXD] = rd_data;
        // transmit empty is also consumed by reading the value that names it
        clr_v[IDX_TXE] = wr_hold | (rd_ident & pick[IDX_TXE]);
        clr_v[IDX_MSC] = rd_modem;
    end

    uirq_flags #(.N(NSRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .pend_o (pend_q)
    );

    uirq_enable #(.N(NSRC)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (en_wr),
        .wdata_i (en_wdata),
        .en_o    (en_q)
    );

    assign active = pend_q & en_q;

    uirq_prio #(.N(NSRC)) u_prio (
        .active_i (active),
        .pick_o   (pick),
        .ident_o  (ident_o)
    );

    assign irq_o = |active;
endmodule

module uirq_checker
    import uirq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            ev_line_err,
    input logic            ev_rx_avail,
    input logic            ev_tx_empty,
    input logic            ev_modem_chg,
    input logic            rd_ident,
    input logic            rd_line,
    input logic            rd_data,
    input logic            rd_modem,
    input logic            wr_hold,
    input logic            irq_o,
    input logic [ID_W-1:0] ident_o,
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] en
);
    a_r2_level_matches_ident: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == !ident_o[0]);

    a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & en) == '0) |-> !irq_o);

    a_r4_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[IDX_LSR] && en[IDX_LSR]) |-> ident_o == 3'b110);

    a_r6_ident_read_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ident && ident_o == 3'b010 && !ev_tx_empty) |=> !pend[IDX_TXE]);

    a_r7_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_line && !ev_line_err) |=> !pend[IDX_LSR]);

    a_r7_data_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !ev_rx_avail) |=> !pend[IDX_RXD]);

    a_r7_modem_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_modem && !ev_modem_chg) |=> !pend[IDX_MSC]);

    a_r8_tx_event_survives: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_empty |=> pend[IDX_TXE]);

    a_r8_rx_event_survives: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_avail |=> pend[IDX_RXD]);

    a_r9_other_read_keeps_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ident && ident_o != 3'b010 && !wr_hold && pend[IDX_TXE]) |=> pend[IDX_TXE]);
endmodule

bind uart_irq_ident uirq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_line_err  (ev_line_err),
    .ev_rx_avail  (ev_rx_avail),
    .ev_tx_empty  (ev_tx_empty),
    .ev_modem_chg (ev_modem_chg),
    .rd_ident     (rd_ident),
    .rd_line      (rd_line),
    .rd_data      (rd_data),
    .rd_modem     (rd_modem),
    .wr_hold      (wr_hold),
    .irq_o        (irq_o),
    .ident_o      (ident_o),
    .pend         (pend_q),
    .en           (en_q)
);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_line_err = 0, ev_rx_avail = 0, ev_tx_empty = 0, ev_modem_chg = 0;
    logic       en_wr = 0;
    logic [3:0] en_wdata = '0;
    logic       rd_ident = 0, rd_line = 0, rd_data = 0, rd_modem = 0, wr_hold = 0;
    logic       irq_o;
    logic [2:0] ident_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic       irq;
        logic [2:0] id;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    uart_irq_ident uut (
        .clk(clk), .rst_n(rst_n),
        .ev_line_err(ev_line_err), .ev_rx_avail(ev_rx_avail),
        .ev_tx_empty(ev_tx_empty), .ev_modem_chg(ev_modem_chg),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .rd_ident(rd_ident), .rd_line(rd_line), .rd_data(rd_data),
        .rd_modem(rd_modem), .wr_hold(wr_hold),
        .irq_o(irq_o), .ident_o(ident_o)
    );

    // monitor: compares outputs away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (irq_o !== e.irq || ident_o !== e.id) begin
                n_bad++;
                $display("FAIL %s: actual irq=%b id=%b expected irq=%b id=%b",
                         e.tag, irq_o, ident_o, e.irq, e.id);
            end
        end
    end

    // ev: [0] line err [1] rx [2] tx [3] modem
    // acc: [0] rd_ident [1] rd_line [2] rd_data [3] rd_modem [4] wr_hold
    task automatic step(input logic [3:0] ev, input logic ew, input logic [3:0] ed,
                        input logic [4:0] acc, input logic xirq,
                        input logic [2:0] xid, input string tag);
        exp_t e;
        @(negedge clk);
        {ev_modem_chg, ev_tx_empty, ev_rx_avail, ev_line_err} = ev;
        en_wr = ew; en_wdata = ed;
        {wr_hold, rd_modem, rd_data, rd_line, rd_ident} = acc;
        @(posedge clk);
        e.irq = xirq; e.id = xid; e.tag = tag;
        sb.push_back(e);
        #1;
        {ev_modem_chg, ev_tx_empty, ev_rx_avail, ev_line_err} = '0;
        en_wr = 0; en_wdata = '0;
        {wr_hold, rd_modem, rd_data, rd_line, rd_ident} = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step(4'b0000, 0, 4'h0, 5'b00000, 0, 3'b001, "R1 reset state");
        step(4'b0010, 0, 4'h0, 5'b00000, 0, 3'b001, "R3 rx set while masked");
        step(4'b0000, 1, 4'hF, 5'b00000, 1, 3'b100, "R10 enable exposes masked rx");
        step(4'b0100, 0, 4'h0, 5'b00000, 1, 3'b100, "R4 rx above tx");
        step(4'b0000, 0, 4'h0, 5'b00100, 1, 3'b010, "R2 level stays after one clear");
        step(4'b0000, 0, 4'h0, 5'b00001, 0, 3'b001, "R6 ident read clears tx / R5");
        step(4'b1011, 0, 4'h0, 5'b00000, 1, 3'b110, "R4 line highest");
        step(4'b0000, 0, 4'h0, 5'b00010, 1, 3'b100, "R7 line read clears line");
        step(4'b0000, 0, 4'h0, 5'b00100, 1, 3'b000, "R4 modem lowest");
        step(4'b0000, 0, 4'h0, 5'b01000, 0, 3'b001, "R7 modem read clears modem");
        step(4'b0100, 0, 4'h0, 5'b00000, 1, 3'b010, "R4 tx code");
        step(4'b0000, 0, 4'h0, 5'b10000, 0, 3'b001, "R7 hold write clears tx");
        step(4'b0110, 0, 4'h0, 5'b00000, 1, 3'b100, "R4 rx and tx");
        step(4'b0000, 0, 4'h0, 5'b00001, 1, 3'b100, "R9 ident read naming rx clears nothing");
        step(4'b0000, 0, 4'h0, 5'b00100, 1, 3'b010, "R9 tx kept after other read");
        step(4'b0100, 0, 4'h0, 5'b00001, 1, 3'b010, "R8 tx event with ident read");
        step(4'b0100, 0, 4'h0, 5'b10000, 1, 3'b010, "R8 tx event with hold write");
        step(4'b0010, 0, 4'h0, 5'b00100, 1, 3'b100, "R8 rx event with data read");
        step(4'b0000, 0, 4'h0, 5'b00100, 1, 3'b010, "R7 data read clears rx");
        step(4'b0000, 1, 4'h0, 5'b00000, 0, 3'b001, "R3 all masked");
        step(4'b0000, 0, 4'h0, 5'b00001, 0, 3'b001, "R9 read while masked");
        step(4'b0000, 1, 4'h4, 5'b00000, 1, 3'b010, "R3 masked tx survived");
        step(4'b1000, 0, 4'h0, 5'b00000, 1, 3'b010, "R3 masked modem invisible");
        step(4'b0000, 0, 4'h0, 5'b10000, 0, 3'b001, "R3 masked modem no irq");
        step(4'b0000, 1, 4'h8, 5'b00000, 1, 3'b000, "R3 modem exposed");
        step(4'b0000, 0, 4'h0, 5'b01000, 0, 3'b001, "R5 none pending");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule